// File: doc/BRIEF.md
# Event Frame Timestamp Capture Latch

This block records the moment a precision-time event frame crosses the receive or transmit point of a network port. On each receive frame strobe it checks the decoded header fields against a programmable event filter. When the frame qualifies and no earlier stamp is still pending, it copies the free-running 64-bit time value into a receive stamp register and raises a receive-valid flag. Transmit capture works the same way, driven by a strobe that marks the one frame software asked to stamp.

A stamp stays locked until software reads the high word of that direction's stamp register. Only then can a new stamp be taken. This single-entry scheme ties every stamp to exactly one frame. In per-packet mode the latch is bypassed: every received frame gets a 16-byte header that carries the capture time, ready to be placed in front of the frame in its buffer.

Top module: `event_stamp_latch`

## Requirements
- R1: After reset the control word at address 0 reads as zero, and `rxValid`, `txValid` and `hdrValid` are low.
- R2: Control word bits: bit0 receive enable, bit1 transmit enable, bits3:2 receive filter, bit4 version-1 message select, bit5 source-port check, bit6 per-packet mode. On read, bit8 shows `rxValid` and bit9 shows `txValid`. A receive capture stores `timeNow` from the strobe's clock edge. The next cycle raises `rxValid`, with the low word at address 1 and the high word at address 2.
- R3: While `rxValid` is high, later qualifying frames are not stamped, and the held value does not change.
- R4: A read of address 2 clears `rxValid` at that clock edge. A read of address 1 leaves it set.
- R5: With transmit enabled, a `txMark` strobe captures `timeNow` into the transmit stamp (low word at address 3, high word at address 4) and raises `txValid`. Further marks are ignored until address 4 is read, which clears `txValid`.
- R6: With its enable bit clear, a direction never captures.
- R7: Filter code 0 stamps nothing. Filter code 3 stamps every received frame, whatever its fields.
- R8: Filter code 1 stamps only version-1 frames that pass the UDP event check and whose message type equals the select bit (0 for Sync, 1 for Delay_Req).
- R9: Filter code 2 stamps version-2 frames with message type 0 to 3 that either carry ethertype 0x88F7 or pass the UDP event check.
- R10: The UDP event check needs IP protocol 17 and destination port 0x013F (319, upper byte first). When source-port check is on, it also needs source port 0x013F.
- R11: In per-packet mode with receive enabled, every received frame causes a one-cycle `hdrValid` on the next cycle. In that header, dwords 0 and 1 (bits 63:0) are zero, dword 2 (bits 95:64) is the time low word and dword 3 (bits 127:96) is the time high word. The stamp latch is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeNow | input | 64 | Current time counter value |
| rxEvt | input | 1 | Receive frame strobe, one cycle per frame |
| rxEtherType | input | 16 | Decoded ethertype of the frame |
| rxIpProto | input | 8 | Decoded IP protocol number |
| rxSrcPort | input | 16 | UDP source port, upper byte first |
| rxDstPort | input | 16 | UDP destination port, upper byte first |
| rxPtpVer | input | 4 | Precision-time protocol version |
| rxMsgType | input | 4 | Precision-time message type |
| txMark | input | 1 | Transmit strobe for the frame to be stamped |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; side effects at the clock edge |
| regAddr | input | 3 | Register address |
| regWdata | input | 7 | Write data, control fields only |
| regRdata | output | 32 | Read data for the addressed register |
| rxValid | output | 1 | Receive stamp held |
| txValid | output | 1 | Transmit stamp held |
| hdrValid | output | 1 | Per-packet header present |
| hdrData | output | 128 | Per-packet header, dword 0 in the low bits |

## Verification
The bench builds the block with its defaults: a 64-bit time split into two 32-bit register words, ethertype 0x88F7 and event port 0x013F. Because each stamp time has distinct high and low halves, a swapped or half-updated word shows up at once. The fixed constants let each filter code be exercised with frames that match or miss on exactly one field. Those fields are version, message type, ethertype, protocol, destination port and source port.

// File: rtl/stamp_latch_pkg.sv
package stamp_latch_pkg;
  localparam int TIME_W  = 64;
  localparam int DATA_W  = TIME_W / 2;
  localparam int HDR_W   = 4 * DATA_W;
  localparam int ADDR_W  = 3;
  localparam int ETYPE_W = 16;
  localparam int PROTO_W = 8;
  localparam int PORT_W  = 16;
  localparam int VER_W   = 4;
  localparam int MSG_W   = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RXLO = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RXHI = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TXLO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TXHI = 3'd4;

  typedef enum logic [1:0] {
    FILT_NONE = 2'd0,
    FILT_V1   = 2'd1,
    FILT_V2   = 2'd2,
    FILT_ALL  = 2'd3
  } rxFilt_e;

  typedef struct packed {
    logic    pktMode;
    logic    srcChk;
    logic    v1Sel;
    rxFilt_e filt;
    logic    txEn;
    logic    rxEn;
  } stampCfg_t;

  localparam int CFG_W = $bits(stampCfg_t);

  typedef struct packed {
    logic rxCap;
    logic txCap;
    logic hdrEmit;
  } stampStrb_t;
endpackage

// File: rtl/stamp_filter.sv
module stamp_filter
  import stamp_latch_pkg::*;
#(
  parameter logic [ETYPE_W-1:0] PTP_ETYPE = 16'h88F7,
  parameter logic [PORT_W-1:0]  EVT_PORT  = 16'h013F,
  parameter logic [PROTO_W-1:0] UDP_PROTO = 8'd17
) (
  input  rxFilt_e             filtSel,
  input  logic                v1Sel,
  input  logic                srcChk,
  input  logic [ETYPE_W-1:0]  etherType,
  input  logic [PROTO_W-1:0]  ipProto,
  input  logic [PORT_W-1:0]   srcPort,
  input  logic [PORT_W-1:0]   dstPort,
  input  logic [VER_W-1:0]    ptpVer,
  input  logic [MSG_W-1:0]    msgType,
  output logic                filtHit
);
  localparam logic [MSG_W-1:0] EVT_LIMIT = MSG_W'(4);

  logic l2Hit, l4Hit, portOk;

  always_comb begin
    portOk  = !srcChk || (srcPort == EVT_PORT);
    l2Hit   = (etherType == PTP_ETYPE);
    l4Hit   = (ipProto == UDP_PROTO) && (dstPort == EVT_PORT) && portOk;
    unique case (filtSel)
      FILT_NONE: filtHit = 1'b0;
      FILT_V1:   filtHit = l4Hit && (ptpVer == VER_W'(1)) &&
                           (msgType == MSG_W'(v1Sel));
      FILT_V2:   filtHit = (l2Hit || l4Hit) && (ptpVer == VER_W'(2)) &&
                           (msgType < EVT_LIMIT);
      default:   filtHit = 1'b1;
    endcase
  end
endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEvt,
  input  logic              txMark,
  input  logic              filtHit,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CFG_W-1:0]  regWdata,
  output stampCfg_t         cfg,
  output logic              rxValid,
  output logic              txValid,
  output stampStrb_t        strb,
  output logic [DATA_W-1:0] statusWord
);
  logic rxRel, txRel;

  always_comb begin
    rxRel        = regRd && (regAddr == ADDR_RXHI);
    txRel        = regRd && (regAddr == ADDR_TXHI);
    strb.rxCap   = rxEvt && cfg.rxEn && !cfg.pktMode && filtHit && !rxValid;
    strb.txCap   = txMark && cfg.txEn && !txValid;
    strb.hdrEmit = rxEvt && cfg.rxEn && cfg.pktMode;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[CFG_W-1:0] = cfg;
    statusWord[8]        = rxValid;
    statusWord[9]        = txValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      rxValid <= 1'b0;
      txValid <= 1'b0;
    end else begin
      if (regWr && (regAddr == ADDR_CTRL)) cfg <= stampCfg_t'(regWdata);
      if (strb.rxCap)      rxValid <= 1'b1;
      else if (rxRel)      rxValid <= 1'b0;
      if (strb.txCap)      txValid <= 1'b1;
      else if (txRel)      txValid <= 1'b0;
    end
  end

  // R3
  rx_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !(regRd && regAddr == ADDR_RXHI) |=> rxValid);
  // R4
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxValid) |-> $past(regRd && regAddr == ADDR_RXHI));
  // R5
  tx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txValid) |-> $past(regRd && regAddr == ADDR_TXHI));
  // R6
  rx_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(cfg.rxEn && rxEvt && filtHit));
  // R6
  tx_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> $past(cfg.txEn && txMark));
endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import stamp_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stampStrb_t        strb,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] regRdata,
  output logic              hdrValid,
  output logic [HDR_W-1:0]  hdrData
);
  logic [TIME_W-1:0] rxStamp, txStamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStamp  <= '0;
      txStamp  <= '0;
      hdrValid <= 1'b0;
      hdrData  <= '0;
    end else begin
      if (strb.rxCap) rxStamp <= timeNow;
      if (strb.txCap) txStamp <= timeNow;
      hdrValid <= strb.hdrEmit;
      if (strb.hdrEmit) hdrData <= {timeNow, {(2*DATA_W){1'b0}}};
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = statusWord;
      ADDR_RXLO: regRdata = rxStamp[DATA_W-1:0];
      ADDR_RXHI: regRdata = rxStamp[TIME_W-1:DATA_W];
      ADDR_TXLO: regRdata = txStamp[DATA_W-1:0];
      ADDR_TXHI: regRdata = txStamp[TIME_W-1:DATA_W];
      default:   regRdata = '0;
    endcase
  end

  // R2
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCap |=> rxStamp == $past(timeNow));
  // R5
  tx_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txCap |=> txStamp == $past(timeNow));
  // R11
  hdr_layout_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> (hdrData[2*DATA_W-1:0] == '0) &&
                 (hdrData[HDR_W-1:2*DATA_W] == $past(timeNow)));
endmodule

// File: rtl/event_stamp_latch.sv
module event_stamp_latch
  import stamp_latch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIME_W-1:0]  timeNow,
  input  logic               rxEvt,
  input  logic [ETYPE_W-1:0] rxEtherType,
  input  logic [PROTO_W-1:0] rxIpProto,
  input  logic [PORT_W-1:0]  rxSrcPort,
  input  logic [PORT_W-1:0]  rxDstPort,
  input  logic [VER_W-1:0]   rxPtpVer,
  input  logic [MSG_W-1:0]   rxMsgType,
  input  logic               txMark,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CFG_W-1:0]   regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               rxValid,
  output logic               txValid,
  output logic               hdrValid,
  output logic [HDR_W-1:0]   hdrData
);
  stampCfg_t         cfg;
  stampStrb_t        strb;
  logic              filtHit;
  logic [DATA_W-1:0] statusWord;

  stamp_filter u_filter (
    .filtSel(cfg.filt), .v1Sel(cfg.v1Sel), .srcChk(cfg.srcChk),
    .etherType(rxEtherType), .ipProto(rxIpProto), .srcPort(rxSrcPort),
    .dstPort(rxDstPort), .ptpVer(rxPtpVer), .msgType(rxMsgType),
    .filtHit(filtHit)
  );

  stamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEvt(rxEvt), .txMark(txMark), .filtHit(filtHit),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .cfg(cfg), .rxValid(rxValid), .txValid(txValid), .strb(strb),
    .statusWord(statusWord)
  );

  stamp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeNow(timeNow), .regAddr(regAddr),
    .statusWord(statusWord), .regRdata(regRdata), .hdrValid(hdrValid),
    .hdrData(hdrData)
  );
endmodule

// File: tb/event_stamp_latch_bench.sv
`timescale 1ns/1ps
module event_stamp_latch_bench;
  localparam int CLK_NS = 20;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [63:0]  timeNow = '0;
  logic         rxEvt = 1'b0;
  logic [15:0]  rxEtherType = '0;
  logic [7:0]   rxIpProto = '0;
  logic [15:0]  rxSrcPort = '0;
  logic [15:0]  rxDstPort = '0;
  logic [3:0]   rxPtpVer = '0;
  logic [3:0]   rxMsgType = '0;
  logic         txMark = 1'b0;
  logic         regWr = 1'b0;
  logic         regRd = 1'b0;
  logic [2:0]   regAddr = '0;
  logic [6:0]   regWdata = '0;
  logic [31:0]  regRdata;
  logic         rxValid, txValid, hdrValid;
  logic [127:0] hdrData;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  event_stamp_latch u_event_stamp_latch (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .rxEvt(rxEvt),
    .rxEtherType(rxEtherType), .rxIpProto(rxIpProto), .rxSrcPort(rxSrcPort),
    .rxDstPort(rxDstPort), .rxPtpVer(rxPtpVer), .rxMsgType(rxMsgType),
    .txMark(txMark), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxValid(rxValid),
    .txValid(txValid), .hdrValid(hdrValid), .hdrData(hdrData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [6:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(posedge clk); @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic rxFrame(input logic [15:0] et, input logic [7:0] pr,
                         input logic [15:0] sp, input logic [15:0] dp,
                         input logic [3:0] ver, input logic [3:0] msg,
                         input logic [63:0] t);
    rxEtherType = et; rxIpProto = pr; rxSrcPort = sp; rxDstPort = dp;
    rxPtpVer = ver; rxMsgType = msg; timeNow = t; rxEvt = 1'b1;
    @(posedge clk); @(negedge clk);
    rxEvt = 1'b0;
  endtask

  task automatic txFrame(input logic [63:0] t);
    timeNow = t; txMark = 1'b1;
    @(posedge clk); @(negedge clk);
    txMark = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 rxValid", 64'(rxValid), 64'd0);
    chk("R1 txValid", 64'(txValid), 64'd0);
    chk("R1 hdrValid", 64'(hdrValid), 64'd0);
    regRead(3'd0, d);
    chk("R1 ctrl word", 64'(d), 64'd0);
  endtask

  task automatic testFilterNone();
    regWrite(3'd0, 7'h01);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd2, 4'd0, 64'h1);
    chk("R7 filter none", 64'(rxValid), 64'd0);
  endtask

  task automatic testV2LockRelease();
    logic [31:0] d;
    regWrite(3'd0, 7'h09);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd2, 4'd0, 64'h1111_2222_3333_4444);
    chk("R9 v2 L2 capture", 64'(rxValid), 64'd1);
    regRead(3'd0, d);
    chk("R2 status bit8", 64'(d[8]), 64'd1);
    regRead(3'd1, d);
    chk("R2 rx low word", 64'(d), 64'h3333_4444);
    chk("R4 low read keeps valid", 64'(rxValid), 64'd1);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd2, 4'd1, 64'h5555_6666_7777_8888);
    regRead(3'd1, d);
    chk("R3 held low word", 64'(d), 64'h3333_4444);
    regRead(3'd2, d);
    chk("R3 held high word", 64'(d), 64'h1111_2222);
    chk("R4 high read clears", 64'(rxValid), 64'd0);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd2, 4'd8, 64'h9);
    chk("R9 general msg rejected", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd6, 16'h013F, 16'h013F, 4'd2, 4'd0, 64'h9);
    chk("R10 tcp rejected", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd17, 16'h0, 16'h013F, 4'd2, 4'd3, 64'hAAAA_0001_BBBB_0002);
    chk("R9 v2 L4 capture", 64'(rxValid), 64'd1);
    regRead(3'd2, d);
    chk("R9 v2 L4 high word", 64'(d), 64'hAAAA_0001);
  endtask

  task automatic testV1();
    logic [31:0] d;
    regWrite(3'd0, 7'h05);
    rxFrame(16'h0800, 8'd17, 16'h0, 16'h013F, 4'd1, 4'd1, 64'h2);
    chk("R8 sel0 rejects delay_req", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd17, 16'h0, 16'h013F, 4'd2, 4'd0, 64'h2);
    chk("R8 v2 frame rejected", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd17, 16'h0, 16'h013F, 4'd1, 4'd0, 64'h0000_0010_0000_0020);
    chk("R8 sel0 sync capture", 64'(rxValid), 64'd1);
    regRead(3'd2, d);
    regWrite(3'd0, 7'h15);
    rxFrame(16'h0800, 8'd17, 16'h0, 16'h013F, 4'd1, 4'd0, 64'h3);
    chk("R8 sel1 rejects sync", 64'(rxValid), 64'd0);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd1, 4'd1, 64'h3);
    chk("R8 L2 only rejected", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd17, 16'h0, 16'h013F, 4'd1, 4'd1, 64'h0000_0030_0000_0040);
    regRead(3'd1, d);
    chk("R8 sel1 delay_req low", 64'(d), 64'h40);
    regRead(3'd2, d);
  endtask

  task automatic testSrcPort();
    logic [31:0] d;
    regWrite(3'd0, 7'h29);
    rxFrame(16'h0800, 8'd17, 16'h1234, 16'h013F, 4'd2, 4'd0, 64'h4);
    chk("R10 src port mismatch", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd17, 16'h013F, 16'h3F01, 4'd2, 4'd0, 64'h4);
    chk("R10 byte-swapped dst rejected", 64'(rxValid), 64'd0);
    rxFrame(16'h0800, 8'd17, 16'h013F, 16'h013F, 4'd2, 4'd0, 64'h0000_0050_0000_0060);
    chk("R10 src port match", 64'(rxValid), 64'd1);
    regRead(3'd2, d);
    chk("R10 high word", 64'(d), 64'h50);
  endtask

  task automatic testAllAndDisable();
    logic [31:0] d;
    regWrite(3'd0, 7'h0D);
    rxFrame(16'h0806, 8'd0, 16'h0, 16'h0, 4'd0, 4'd15, 64'h0000_0070_0000_0080);
    chk("R7 all captures any frame", 64'(rxValid), 64'd1);
    regRead(3'd1, d);
    chk("R7 all low word", 64'(d), 64'h80);
    regRead(3'd2, d);
    regWrite(3'd0, 7'h0C);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd2, 4'd0, 64'h5);
    chk("R6 rx disabled", 64'(rxValid), 64'd0);
  endtask

  task automatic testTx();
    logic [31:0] d;
    txFrame(64'h6);
    chk("R6 tx disabled", 64'(txValid), 64'd0);
    regWrite(3'd0, 7'h02);
    txFrame(64'hCAFE_0001_BEEF_0002);
    chk("R5 tx capture", 64'(txValid), 64'd1);
    regRead(3'd0, d);
    chk("R5 status bit9", 64'(d[9]), 64'd1);
    txFrame(64'h1234_5678_9ABC_DEF0);
    regRead(3'd3, d);
    chk("R5 tx low held", 64'(d), 64'hBEEF_0002);
    chk("R5 low read keeps tx valid", 64'(txValid), 64'd1);
    regRead(3'd4, d);
    chk("R5 tx high held", 64'(d), 64'hCAFE_0001);
    chk("R5 tx released", 64'(txValid), 64'd0);
  endtask

  task automatic testPktMode();
    regWrite(3'd0, 7'h41);
    rxFrame(16'h0806, 8'd0, 16'h0, 16'h0, 4'd0, 4'd9, 64'hDEAD_0001_F00D_0002);
    chk("R11 header valid", 64'(hdrValid), 64'd1);
    chk("R11 header dwords 3:2", hdrData[127:64], 64'hDEAD_0001_F00D_0002);
    chk("R11 header dwords 1:0", hdrData[63:0], 64'd0);
    chk("R11 latch untouched", 64'(rxValid), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R11 header one cycle", 64'(hdrValid), 64'd0);
    regWrite(3'd0, 7'h40);
    rxFrame(16'h88F7, 8'd0, 16'h0, 16'h0, 4'd2, 4'd0, 64'h7);
    chk("R11 needs rx enable", 64'(hdrValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFilterNone();
    testV2LockRelease();
    testV1();
    testSrcPort();
    testAllAndDisable();
    testTx();
    testPktMode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule